// File: doc/BRIEF.md
# Test access port with high-impedance sampling

This block is the serial test port of a memory device. It is driven by four signals: a test clock, a mode select, serial data in and serial data out. A sixteen-state controller, stepped by the mode select on each rising test clock, decides whether the instruction register or a data register sits between serial in and serial out. There is no dedicated test reset pin. An asynchronous power-on reset from the chip puts the controller in its reset state. Holding the mode select high for five clocks does the same from any state.

The instruction register is three bits wide and selects one of three data paths: the 32-bit identification register, the one-bit bypass register, or a boundary register of parameterised length. The boundary register takes a parallel snapshot of the device pins. Two instruction codes sample the pins while forcing the memory data pins to high impedance, through the `dq_hiz` output. A third code samples without forcing. The three codes left unassigned behave as bypass. No boundary update stage exists, so the port can observe pins but cannot drive them.

Top module: `tap_sz`

## Requirements
- R1: While `por_n` is low and just after it rises, the controller is in its reset state, the active instruction is 001, `tdo_en` is 0 and `dq_hiz` is 0.
- R2: The controller follows the standard sixteen-state test port graph on rising `tck`. Five consecutive rising edges with `tms` high reach the reset state from any state.
- R3: In Capture-IR the instruction shifter loads 001. It shifts least significant bit first, with `tdi` entering at bit 2. The shifted value becomes the active instruction on the rising edge that leaves Update-IR.
- R4: Every rising edge in the reset state sets the active instruction to 001 (IDCODE).
- R5: Codes 000 and 010 select the boundary register and drive `dq_hiz` to 1.
- R6: Code 100 selects the boundary register and leaves `dq_hiz` at 0.
- R7: Code 001 selects a 32-bit identification register. It captures `ID_WORD` with bit 0 forced to 1 and shifts out least significant bit first.
- R8: Codes 111, 011, 101 and 110 select the one-bit bypass register, which delays `tdi` by one clock.
- R9: The bypass register clears to 0 in Update-IR and in the reset state. Capture-DR does not clear it, so it keeps the last bit shifted in across a later data scan.
- R10: In Capture-DR the boundary register loads `bnd_in`. It shifts `bnd_in[0]` out first, with `tdi` entering at bit `BSR_LEN-1`.
- R11: `tdo` and `tdo_en` change only on falling `tck`. `tdo_en` is 1 exactly while the controller is in Shift-IR or Shift-DR.
- R12: Pause-DR and Exit2-DR hold the data register contents, ignore `bnd_in`, and let shifting resume where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| bnd_in | input | BSR_LEN | Parallel pin values captured into the boundary register |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_en | output | 1 | Output enable for `tdo` |
| dq_hiz | output | 1 | Forces the memory data pins to high impedance |

## Verification
The bench sweeps all eight instruction codes and checks each one's path length, captured value and high-impedance flag. A wrong decode would show up as a shifted output stream or a stray `dq_hiz`. It also checks that a bypass bit survives across two data scans and is cleared by an instruction update. A design that cleared the bypass register on every capture, or never cleared it, would present the wrong first bit. A scan is split by a pause while `bnd_in` changes, which exposes any recapture or lost bit. The five-high escape is taken from inside Shift-DR, and `tdo` is compared across rising edges, which catches an output register on the wrong clock edge.

// File: rtl/tap_sz.sv
module tap_sz #(
  parameter int          BSR_LEN = 70,
  parameter logic [31:0] ID_WORD = 32'h2D51_C0F5
) (
  input  logic               tck,
  input  logic               tms,
  input  logic               tdi,
  input  logic               por_n,
  input  logic [BSR_LEN-1:0] bnd_in,
  output logic               tdo,
  output logic               tdo_en,
  output logic               dq_hiz
);

  localparam logic [31:0] ID_FIX = {ID_WORD[31:1], 1'b1};
  localparam logic [2:0]  OP_IDC = 3'b001;

  typedef enum logic [3:0] {
    TLR, RTI, SDR, CDR, SHD, E1D, PDR, E2D, UDR,
    SIR, CIR, SHI, E1I, PIR, E2I, UIR
  } st_t;

  st_t                st, nx;
  logic [2:0]         ir_q, ir_sh;
  logic               byp;
  logic [31:0]        id_sh;
  logic [BSR_LEN-1:0] bsr_sh;
  logic               sel_id, sel_bsr;
  logic [2:0]         hi_cnt;

  assign sel_id  = (ir_q == OP_IDC);
  assign sel_bsr = (ir_q == 3'b000) || (ir_q == 3'b010) || (ir_q == 3'b100);
  assign dq_hiz  = (ir_q == 3'b000) || (ir_q == 3'b010);

  always_comb begin
    case (st)
      TLR:     nx = tms ? TLR : RTI;
      RTI:     nx = tms ? SDR : RTI;
      SDR:     nx = tms ? SIR : CDR;
      CDR:     nx = tms ? E1D : SHD;
      SHD:     nx = tms ? E1D : SHD;
      E1D:     nx = tms ? UDR : PDR;
      PDR:     nx = tms ? E2D : PDR;
      E2D:     nx = tms ? UDR : SHD;
      UDR:     nx = tms ? SDR : RTI;
      SIR:     nx = tms ? TLR : CIR;
      CIR:     nx = tms ? E1I : SHI;
      SHI:     nx = tms ? E1I : SHI;
      E1I:     nx = tms ? UIR : PIR;
      PIR:     nx = tms ? E2I : PIR;
      E2I:     nx = tms ? UIR : SHI;
      UIR:     nx = tms ? SDR : RTI;
      default: nx = TLR;
    endcase
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      st     <= TLR;
      ir_q   <= OP_IDC;
      ir_sh  <= OP_IDC;
      byp    <= 1'b0;
      id_sh  <= '0;
      bsr_sh <= '0;
    end else begin
      st <= nx;
      case (st)
        TLR: begin
          ir_q <= OP_IDC;
          byp  <= 1'b0;
        end
        CIR: ir_sh <= OP_IDC;
        SHI: ir_sh <= {tdi, ir_sh[2:1]};
        UIR: begin
          ir_q <= ir_sh;
          byp  <= 1'b0;
        end
        CDR: begin
          if (sel_id)  id_sh  <= ID_FIX;
          if (sel_bsr) bsr_sh <= bnd_in;
        end
        SHD: begin
          if (sel_id)       id_sh  <= {tdi, id_sh[31:1]};
          else if (sel_bsr) bsr_sh <= {tdi, bsr_sh[BSR_LEN-1:1]};
          else              byp    <= tdi;
        end
        default: ;
      endcase
    end
  end

  always_ff @(negedge tck or negedge por_n) begin
    if (!por_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo_en <= (st == SHI) || (st == SHD);
      tdo    <= (st == SHI) ? ir_sh[0] :
                sel_id      ? id_sh[0] :
                sel_bsr     ? bsr_sh[0] : byp;
    end
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)              hi_cnt <= '0;
    else if (!tms)           hi_cnt <= '0;
    else if (hi_cnt != 3'd5) hi_cnt <= hi_cnt + 3'd1;
  end

  p_five_high_r2: assert property (@(posedge tck) disable iff (!por_n)
    (hi_cnt == 3'd5) |-> (st == TLR));

  p_ir_capture_r3: assert property (@(posedge tck) disable iff (!por_n)
    (st == CIR) |=> (ir_sh == 3'b001));

  p_reset_idcode_r4: assert property (@(posedge tck) disable iff (!por_n)
    (st == TLR) |=> (ir_q == OP_IDC));

  p_samplez_hiz_r5: assert property (@(posedge tck) disable iff (!por_n)
    (st == UIR && (ir_sh == 3'b000 || ir_sh == 3'b010)) |=> dq_hiz);

  p_sample_nohiz_r6: assert property (@(posedge tck) disable iff (!por_n)
    (st == UIR && ir_sh == 3'b100) |=> !dq_hiz);

  p_id_lsb_r7: assert property (@(posedge tck) disable iff (!por_n)
    (st == CDR && ir_q == OP_IDC) |=> id_sh[0]);

  p_byp_clear_r9: assert property (@(posedge tck) disable iff (!por_n)
    (st == UIR) |=> !byp);

  p_pause_hold_r12: assert property (@(posedge tck) disable iff (!por_n)
    (st == PDR) |=> ($stable(bsr_sh) && $stable(id_sh) && $stable(byp)));

endmodule

// File: tb/sim_tap_sz.sv
module sim_tap_sz;
  localparam int          BL     = 70;
  localparam logic [31:0] ID_IN  = 32'hC35A_96E4;
  localparam logic [31:0] ID_EXP = 32'hC35A_96E5;

  logic tck = 1'b0, tms = 1'b1, tdi = 1'b0, por_n = 1'b0;
  logic [BL-1:0] bnd_in = '0;
  logic tdo, tdo_en, dq_hiz;
  int total = 0, bad = 0, en_bad = 0, rise_chg = 0;
  bit done = 0;

  tap_sz #(.BSR_LEN(BL), .ID_WORD(ID_IN)) u0 (
    .tck(tck), .tms(tms), .tdi(tdi), .por_n(por_n), .bnd_in(bnd_in),
    .tdo(tdo), .tdo_en(tdo_en), .dq_hiz(dq_hiz));

  always #5 tck = ~tck;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic t, input logic d, output logic o, output logic oe);
    logic o2;
    @(negedge tck); #2;
    o = tdo; oe = tdo_en; tms = t; tdi = d;
    @(posedge tck); #1;
    o2 = tdo;
    if (o2 !== o) rise_chg++;
  endtask

  task automatic load_ir(input logic [2:0] code, output logic [2:0] cap);
    logic o, oe;
    tick(1, 0, o, oe); tick(1, 0, o, oe); tick(0, 0, o, oe); tick(0, 0, o, oe);
    for (int i = 0; i < 3; i++) begin
      tick(i == 2, code[i], o, oe);
      cap[i] = o;
      if (oe !== 1'b1) en_bad++;
    end
    tick(1, 0, o, oe); tick(0, 0, o, oe);
    if (oe !== 1'b0) en_bad++;
  endtask

  task automatic scan_dr(input int n, input logic [127:0] din, output logic [127:0] dout);
    logic o, oe;
    dout = '0;
    tick(1, 0, o, oe); tick(0, 0, o, oe); tick(0, 0, o, oe);
    for (int i = 0; i < n; i++) begin
      tick(i == n - 1, din[i], o, oe);
      dout[i] = o;
      if (oe !== 1'b1) en_bad++;
    end
    tick(1, 0, o, oe); tick(0, 0, o, oe);
    if (oe !== 1'b0) en_bad++;
  endtask

  function automatic logic [127:0] expect_out(logic [127:0] cap, int len,
                                               logic [127:0] din, int n);
    logic [127:0] e = '0;
    for (int i = 0; i < n; i++) e[i] = (i < len) ? cap[i] : din[i - len];
    return e;
  endfunction

  function automatic logic [BL-1:0] pat(int seed);
    logic [BL-1:0] p;
    for (int j = 0; j < BL; j++) p[j] = ((j * 7 + seed * 3) % 5) < 2;
    return p;
  endfunction

  initial begin
    logic [2:0] cap;
    logic [127:0] din, dout, capv;
    logic o, oe;
    int len;

    repeat (3) @(posedge tck);
    #1;
    chk("R1 tdo_en in reset", tdo_en, 0);
    chk("R1 dq_hiz in reset", dq_hiz, 0);
    por_n = 1'b1;
    tick(0, 0, o, oe);
    chk("R1 tdo_en after reset", oe, 0);

    din = {4{32'hA5C3_1E69}};
    scan_dr(40, din, dout);
    chk("R7 default IDCODE scan", dout, expect_out({96'b0, ID_EXP}, 32, din, 40));

    for (int code = 0; code < 8; code++) begin
      bnd_in = pat(code);
      load_ir(code[2:0], cap);
      chk("R3 IR capture pattern", cap, 3'b001);
      if (code == 0 || code == 2) chk("R5 SAMPLE-Z high-Z", dq_hiz, 1);
      else if (code == 4)         chk("R6 SAMPLE no high-Z", dq_hiz, 0);
      else                        chk("R8 no high-Z", dq_hiz, 0);
      din = {4{32'h6B1F_D40C}} ^ 128'(code * 977);
      if (code == 1) begin
        len = 32; capv = {96'b0, ID_EXP};
      end else if (code == 0 || code == 2 || code == 4) begin
        len = BL; capv = {58'b0, bnd_in};
      end else begin
        len = 1; capv = '0;
      end
      scan_dr(len + 8, din, dout);
      if (code == 1)     chk("R7 IDCODE path", dout, expect_out(capv, len, din, len + 8));
      else if (len == 1) chk("R8 bypass path", dout, expect_out(capv, len, din, len + 8));
      else               chk("R10 boundary path", dout, expect_out(capv, len, din, len + 8));
    end

    load_ir(3'b111, cap);
    din = 128'h00A5_5F0F;
    scan_dr(24, din, dout);
    din = 128'h0000_0F3C;
    scan_dr(24, din, dout);
    chk("R9 bypass holds last bit", dout[0], 1'b0 ^ 1'b0 ^ 1'b1);
    load_ir(3'b101, cap);
    scan_dr(24, din, dout);
    chk("R9 bypass cleared by update", dout[0], 0);

    load_ir(3'b000, cap);
    chk("R5 high-Z before escape", dq_hiz, 1);
    for (int i = 0; i < 5; i++) tick(1, 0, o, oe);
    tick(0, 0, o, oe);
    chk("R4 escape from idle", dq_hiz, 0);
    load_ir(3'b010, cap);
    tick(1, 0, o, oe); tick(0, 0, o, oe); tick(0, 0, o, oe);
    for (int i = 0; i < 5; i++) tick(1, 0, o, oe);
    tick(0, 0, o, oe);
    chk("R2 escape from Shift-DR", dq_hiz, 0);
    din = 128'h1234;
    scan_dr(34, din, dout);
    chk("R4 IDCODE after escape", dout, expect_out({96'b0, ID_EXP}, 32, din, 34));

    bnd_in = pat(11);
    load_ir(3'b100, cap);
    capv = {58'b0, bnd_in};
    dout = '0;
    tick(1, 0, o, oe); tick(0, 0, o, oe); tick(0, 0, o, oe);
    for (int i = 0; i < 10; i++) begin
      tick(i == 9, 0, o, oe);
      dout[i] = o;
    end
    tick(0, 0, o, oe);
    tick(0, 0, o, oe);
    chk("R11 tdo_en low in Pause-DR", oe, 0);
    bnd_in = ~bnd_in;
    tick(1, 0, o, oe);
    tick(0, 0, o, oe);
    for (int i = 10; i < BL; i++) begin
      tick(i == BL - 1, 0, o, oe);
      dout[i] = o;
    end
    tick(1, 0, o, oe); tick(0, 0, o, oe);
    chk("R12 scan resumes after pause", dout, capv);

    chk("R11 tdo_en only in shift states", en_bad, 0);
    chk("R11 tdo stable across rising edge", rise_chg, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule